// File: doc/BRIEF.md
# Read-Only Memory Self-Test Controller with Signature Compaction

This controller checks a synchronous single-port ROM without reading it out over a bus. On a start request it drives every ROM address once, in ascending order, with the ROM output enable held high. It folds each returned word into a 23-bit multiple-input signature register. When the sweep ends it compares the compacted value against a golden signature fixed at build time. The result appears on `done` and `pass`. The final register contents stay visible on `signature` for diagnosis.

The ROM samples its address on the rising clock edge and returns data with no added latency. The controller itself runs on the falling edge, so every word is settled half a cycle before it is captured. Reset is synchronous to that falling edge. A run with the default 2048-word ROM takes exactly 2052 falling edges. That count is the 2048 captures plus four edges:
- the edge that accepts the request and loads the seed,
- a priming edge while the first word is in flight,
- a flush edge,
- the compare edge.

Top module: `rom_sig_checker`

## Requirements
- R1: With `rst` high at a falling edge, `busy`, `done`, `pass` and `rom_oe` are 0, `rom_addr` is 0, and `signature` holds the seed after that edge, whatever the run state was.
- R2: A high `start` at a falling edge is accepted only while `busy` is 0 and `rst` is 0. Acceptance sets `busy`, clears `done` and `pass`, and loads the seed. A `start` seen while `busy` is 1, including on the compare edge, is ignored and leaves the run length unchanged.
- R3: While `busy` is 1, `rom_oe` is 1 and `rom_addr` starts at 0 and rises by exactly one per cycle up to 2^ADDR_W-1, with no other change. While idle, `rom_oe` is 0.
- R4: The compaction register is loaded with 23'b10010101011100001010011 (bit 22 on the left) at acceptance.
- R5: Each capture replaces the register m with n, where n[0] = m[22]^d[0], n[5] = m[4]^m[22]^d[5], n[i] = m[i-1]^d[i] for the other i in 1..11, and n[i] = m[i-1] for i in 12..22. Here d is the 12-bit ROM word, so the polynomial is x^23+x^5+1. Exactly 2^ADDR_W words are captured, those of addresses 0 to 2^ADDR_W-1 in order.
- R6: `done` rises at the falling edge that is the (2^ADDR_W+4)-th counted from the accepting edge, which is 2052 for the default size. `busy` falls at that same edge, and `done` and `busy` are never both 1.
- R7: At the compare edge, `pass` becomes 1 exactly when the final signature equals the GOLDEN parameter. A single flipped ROM bit at any address gives `pass` = 0.
- R8: After completion, `done`, `pass` and `signature` hold until the next accepted start or reset, and a new run after a failing one can pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controller acts on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a self-test run |
| rom_data | input | DATA_W | Word returned by the ROM |
| rom_addr | output | ADDR_W | ROM address |
| rom_oe | output | 1 | ROM output enable, active high |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Signature matched the golden value |
| signature | output | SIG_W | Compaction register contents |

## Verification
A new start request can land on the same edge as the final compare, and a reset can coincide with a start request. The bench raises `start` for exactly the cycle ahead of the compare edge. It then judges that `done` appears at the nominal edge count, that `pass` is correct, and that the controller stays idle afterwards. It also holds `rst` and `start` high together, then confirms that no run begins. Expected signatures come from an independent software compaction of the bench's ROM model, including runs with a single bit flipped at the first, last and a middle address.

// File: rtl/rom_sig_checker.sv
module rom_sig_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 12,
  parameter int SIG_W  = 23,
  parameter int TAP    = 5,
  parameter logic [SIG_W-1:0] SEED   = 23'b10010101011100001010011,
  parameter logic [SIG_W-1:0] GOLDEN = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_oe,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [SIG_W-1:0]  signature
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 2;
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] C_CMP  = CNT_W'(DEPTH + 2);

  logic [CNT_W-1:0] cnt;
  logic             capture;

  function automatic logic [SIG_W-1:0] compact(input logic [SIG_W-1:0] m,
                                               input logic [DATA_W-1:0] d);
    logic [SIG_W-1:0] r;
    logic fb;
    fb = m[SIG_W-1];
    r = {m[SIG_W-2:0], fb};
    r[TAP] = r[TAP] ^ fb;
    r[DATA_W-1:0] = r[DATA_W-1:0] ^ d;
    return r;
  endfunction

  assign rom_oe  = busy;
  assign capture = busy && (cnt != '0) && (cnt <= C_LAST);

  always_ff @(negedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      cnt       <= '0;
      rom_addr  <= '0;
      signature <= SEED;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        pass      <= 1'b0;
        cnt       <= '0;
        rom_addr  <= '0;
        signature <= SEED;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt < C_LAST) rom_addr <= cnt[ADDR_W-1:0];
      if (capture) signature <= compact(signature, rom_data);
      if (cnt == C_CMP) begin
        busy <= 1'b0;
        done <= 1'b1;
        pass <= (signature == GOLDEN);
      end
    end
  end

  assert_reset_clears_R1: assert property (@(negedge clk)
    rst |=> (!busy && !done && !pass && !rom_oe && rom_addr == '0 && signature == SEED));

  assert_start_launch_R2: assert property (@(negedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && !pass && signature == SEED));

  assert_busy_ends_in_done_R2: assert property (@(negedge clk) disable iff (rst)
    busy |=> (busy || done));

  assert_addr_step_R3: assert property (@(negedge clk) disable iff (rst)
    (busy && cnt != '0 && cnt < C_LAST) |=> rom_addr == ADDR_W'($past(rom_addr) + 1'b1));

  assert_done_exclusive_R6: assert property (@(negedge clk) disable iff (rst)
    !(busy && done));

  assert_pass_needs_done_R7: assert property (@(negedge clk) disable iff (rst)
    pass |-> done);

  assert_idle_hold_R8: assert property (@(negedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(signature) && $stable(done) && $stable(pass) && $stable(rom_addr)));

endmodule

// File: tb/rom_sig_checker_bench.sv
module rom_sig_checker_bench;

  localparam int SAW   = 5;
  localparam int FAW   = 11;
  localparam logic [22:0] SEED = 23'b10010101011100001010011;

  function automatic logic [11:0] rom_word(input bit pat, input bit fen,
                                           input int faddr, input int fbit, input int a);
    logic [11:0] w;
    logic [11:0] a12;
    a12 = 12'(a);
    if (!pat) w = 12'(a12 * 12'd173 + 12'h5A3) ^ 12'(a12 << 3);
    else      w = ~a12 ^ 12'h3C6;
    if (fen && a == faddr) w[fbit] = ~w[fbit];
    return w;
  endfunction

  function automatic logic [22:0] ref_sig(input int aw, input bit pat, input bit fen,
                                          input int faddr, input int fbit);
    logic [22:0] m, n;
    logic [11:0] d;
    m = SEED;
    for (int a = 0; a < (1 << aw); a++) begin
      d = rom_word(pat, fen, faddr, fbit, a);
      for (int i = 0; i < 23; i++) begin
        n[i] = (i == 0) ? m[22] : m[i-1];
        if (i == 5) n[i] = n[i] ^ m[22];
        if (i < 12) n[i] = n[i] ^ d[i];
      end
      m = n;
    end
    return m;
  endfunction

  localparam logic [22:0] GOLD_S = ref_sig(SAW, 1'b0, 1'b0, 0, 0);

  // {pat, flip_en, flip_addr[4:0], flip_bit[3:0], expected_pass}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 1'b0, 5'd0,  4'd0,  1'b1},
    {1'b0, 1'b1, 5'd0,  4'd0,  1'b0},
    {1'b0, 1'b1, 5'd31, 4'd11, 1'b0},
    {1'b0, 1'b1, 5'd13, 4'd5,  1'b0},
    {1'b1, 1'b0, 5'd0,  4'd0,  1'b0},
    {1'b0, 1'b0, 5'd0,  4'd0,  1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic start_f = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0]    q_s, q_f;
  logic [SAW-1:0] addr_s;
  logic [FAW-1:0] addr_f;
  logic oe_s, busy_s, done_s, pass_s, oe_f, busy_f, done_f, pass_f;
  logic [22:0] sig_s, sig_f;

  rom_sig_checker #(.ADDR_W(SAW), .GOLDEN(GOLD_S)) u_rom_sig_checker (
    .clk(clk), .rst(rst), .start(start), .rom_data(q_s), .rom_addr(addr_s),
    .rom_oe(oe_s), .busy(busy_s), .done(done_s), .pass(pass_s), .signature(sig_s));

  rom_sig_checker #(.ADDR_W(FAW)) u_full (
    .clk(clk), .rst(rst), .start(start_f), .rom_data(q_f), .rom_addr(addr_f),
    .rom_oe(oe_f), .busy(busy_f), .done(done_f), .pass(pass_f), .signature(sig_f));

  bit cur_pat, cur_fen;
  int cur_faddr, cur_fbit;
  int s_steps, s_bad, s_prev, f_steps, f_bad, f_prev;
  bit s_seen, f_seen;

  always @(posedge clk) begin
    if (oe_s) begin
      q_s <= rom_word(cur_pat, cur_fen, cur_faddr, cur_fbit, int'(addr_s));
      if (!s_seen) begin s_seen = 1; if (addr_s != 0) s_bad++; end
      else if (int'(addr_s) != s_prev) begin
        if (int'(addr_s) == s_prev + 1) s_steps++; else s_bad++;
      end
      s_prev = int'(addr_s);
    end
    if (oe_f) begin
      q_f <= rom_word(1'b0, 1'b0, 0, 0, int'(addr_f));
      if (!f_seen) begin f_seen = 1; if (addr_f != 0) f_bad++; end
      else if (int'(addr_f) != f_prev) begin
        if (int'(addr_f) == f_prev + 1) f_steps++; else f_bad++;
      end
      f_prev = int'(addr_f);
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_small(input int poke, output int cyc);
    int k;
    @(posedge clk);
    s_seen = 0; s_steps = 0; s_bad = 0;
    start = 1'b1;
    @(posedge clk);
    start = 1'b0;
    k = 1;
    while (!done_s && k < 200) begin
      @(posedge clk);
      k++;
      start = (k == poke);
    end
    @(posedge clk);
    start = 1'b0;
    cyc = k;
  endtask

  initial begin
    int cyc;
    logic [22:0] ref_v, held;
    repeat (3) @(posedge clk);
    chk(!busy_s && !done_s && !pass_s && !oe_s, "R1 reset flags", {busy_s, done_s, pass_s, oe_s}, 0);
    chk(addr_s == 0, "R1 reset address", addr_s, 0);
    chk(sig_s == SEED, "R4 seed after reset", sig_s, SEED);

    start = 1'b1;
    @(posedge clk);
    @(posedge clk);
    chk(!busy_s, "R2 reset wins over start", busy_s, 0);
    rst = 1'b0;
    start = 1'b0;
    @(posedge clk);
    chk(!busy_s && !done_s, "R2 no run after reset+start", {busy_s, done_s}, 0);

    for (int v = 0; v < 6; v++) begin
      cur_pat   = VEC[v][11];
      cur_fen   = VEC[v][10];
      cur_faddr = int'(VEC[v][9:5]);
      cur_fbit  = int'(VEC[v][4:1]);
      ref_v = ref_sig(SAW, cur_pat, cur_fen, cur_faddr, cur_fbit);
      run_small(0, cyc);
      chk(cyc == (1 << SAW) + 4, "R6 run length", cyc, (1 << SAW) + 4);
      chk(sig_s == ref_v, "R5 signature", sig_s, ref_v);
      chk(pass_s == VEC[v][0], "R7 pass verdict", pass_s, VEC[v][0]);
      chk(s_steps == (1 << SAW) - 1 && s_bad == 0, "R3 address sweep", s_steps, (1 << SAW) - 1);
      chk(!oe_s && !busy_s, "R3 idle enable", oe_s, 0);
      held = sig_s;
      repeat (4) @(posedge clk);
      chk(sig_s == held && done_s && pass_s == VEC[v][0], "R8 result holds", sig_s, held);
    end

    cur_pat = 0; cur_fen = 0;
    run_small(10, cyc);
    chk(cyc == (1 << SAW) + 4, "R2 mid-run start ignored", cyc, (1 << SAW) + 4);
    chk(pass_s, "R7 pass after ignored start", pass_s, 1);

    run_small((1 << SAW) + 3, cyc);
    chk(cyc == (1 << SAW) + 4, "R2 start on compare edge run length", cyc, (1 << SAW) + 4);
    chk(!busy_s && done_s && pass_s, "R2 start on compare edge ignored", {busy_s, done_s, pass_s}, 3'b011);

    @(posedge clk); start = 1'b1;
    @(posedge clk); start = 1'b0;
    chk(busy_s && !done_s && !pass_s, "R8 new start clears result", {busy_s, done_s, pass_s}, 3'b100);
    repeat (6) @(posedge clk);
    rst = 1'b1;
    @(posedge clk);
    rst = 1'b0;
    chk(!busy_s && !done_s && sig_s == SEED, "R1 reset during run", busy_s, 0);

    ref_v = ref_sig(FAW, 1'b0, 1'b0, 0, 0);
    f_seen = 0; f_steps = 0; f_bad = 0;
    @(posedge clk); start_f = 1'b1;
    @(posedge clk); start_f = 1'b0;
    cyc = 1;
    while (!done_f && cyc < 3000) begin @(posedge clk); cyc++; end
    chk(cyc == 2052, "R6 full-size run length", cyc, 2052);
    chk(sig_f == ref_v, "R5 full-size signature", sig_f, ref_v);
    chk(pass_f == (ref_v == 23'd0), "R7 full-size mismatch verdict", pass_f, ref_v == 23'd0);
    chk(f_steps == 2047 && f_bad == 0, "R3 full-size sweep", f_steps, 2047);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule